// File: doc/BRIEF.md
# Two-Wire Serial Slave with Busy Refusal

This block is the bus-facing front end of a small slave device on a two-wire serial bus. It runs from a fast system clock and oversamples the clock line and the data line. It recognises START and STOP and receives bytes most significant bit first. It acknowledges by enabling an open-drain pull-down on the data line. Once the address byte matches, a write transfer loads a register pointer and then writes successive registers through a simple write strobe. A read transfer returns register contents from the same pointer. The pointer advances by one after each byte.

A busy input marks that a slow nonvolatile write is in progress. While it is high, the slave refuses new address bytes and incoming write data with a not-acknowledge. It returns to normal acknowledging as soon as busy falls. During a read, a missing master acknowledge ends the burst, and the slave leaves the data line released so that the master can finish with STOP.

Top module: `twi_slave_top`

## Requirements
- R1: While reset is held and straight after it, `sda_oe` is 0 and `reg_we` is 0.
- R2: STOP (data rising while clock high) returns the slave to idle. Bytes clocked after a STOP and without a new START get no acknowledge and write nothing.
- R3: A first byte after START whose upper seven bits equal `DEV_ADDR` is acknowledged by `sda_oe` high through the ninth clock. Bit 0 of that byte selects direction (0 write, 1 read).
- R4: A first byte with any other address gets no acknowledge. Every later byte up to the next START or STOP is ignored, with no acknowledge and no write.
- R5: In a write, the first data byte sets the register pointer from its low `PTR_W` bits. Each further byte pulses `reg_we` for one cycle with `reg_addr` equal to the pointer, and the pointer then advances by one.
- R6: In a read, the slave drives the register at the pointer most significant bit first (`sda_oe` = inverted bit) and advances the pointer after each byte. A master acknowledge makes it send the next register.
- R7: If the master does not acknowledge a read byte, the slave keeps `sda_oe` at 0 for all further clocks until the next START or STOP.
- R8: While `nv_busy` is 1, a matching address byte and incoming write data bytes get no acknowledge, and refused data is not written. Once `nv_busy` is 0, normal acknowledging resumes.
- R9: A repeated START ends the current transfer. The next byte is treated as an address byte, and the first data byte after it is again a pointer.
- R10: A pulse of 2 system clocks or less on either line is ignored. It creates no clock edge, no START and no STOP.
- R11: `sda_oe` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| nv_busy | input | 1 | Nonvolatile write in progress, refuse transfers |
| reg_addr | output | PTR_W | Register pointer used for reads and writes |
| reg_wdata | output | 8 | Data for the register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
Single-register writes, each followed by a pointer-set-then-read, are driven at matching and non-matching addresses. These show that address compare and pointer load work and that a refused address really leaves the registers alone. Three-byte bursts in both directions tell per-byte pointer advance apart from a pointer that stays put, and the clocks sent after a master NACK show whether the slave really lets go of the line. Repeated START mid-write, bytes after STOP, busy toggled around address and data bytes, and short glitches on both lines during a data bit show that the byte-phase reset, refusal and filtering each act alone.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } twi_state_e;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   line_q;
  logic                   line_d;

  // the filtered level moves only when the whole window agrees
  always_comb begin
    line_d = line_q;
    if (&win_q)       line_d = 1'b1;
    else if (~|win_q) line_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      line_q <= line_d;
    end
  end

  assign line_o = line_q;

  // a filtered change must agree with the synchronised level that fed it
  p_filter_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q != $past(line_q)) |-> ($past(sync_q[SYNC_STAGES-1]) == line_q));
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise = scl_f & ~scl_q;
    scl_fall = ~scl_f & scl_q;
    start_ev = scl_f & scl_q & sda_q & ~sda_f;
    stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  end
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A,
  parameter int         PTR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              nv_busy,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam int               CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  twi_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              first_q, first_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d;
  logic              mack_q, mack_d;
  logic              byte_end;
  logic              addr_hit;

  assign byte_end = scl_fall && (cnt_q == CNT_FULL);
  assign addr_hit = (shift_q[BYTE_W-1:1] == DEV_ADDR);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    wdata_d = wdata_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    first_d = first_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    we_d    = 1'b0;
    // advance the pointer in the cycle after a write strobe
    if (we_q) ptr_d = ptr_q + PTR_W'(1);

    if (stop_ev) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      first_d = 1'b1;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_f};
            cnt_d   = cnt_q + CNT_ONE;
          end else if (byte_end) begin
            if (addr_hit && !nv_busy) begin
              oe_d    = 1'b1;
              rw_d    = shift_q[0];
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              shift_d = reg_rdata;
              oe_d    = ~reg_rdata[BYTE_W-1];
              state_d = ST_RD;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_f};
            cnt_d   = cnt_q + CNT_ONE;
          end else if (byte_end) begin
            if (nv_busy) begin
              state_d = ST_SKIP;
            end else begin
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
              if (first_q) begin
                ptr_d   = shift_q[PTR_W-1:0];
                first_d = 1'b0;
              end else begin
                we_d    = 1'b1;
                wdata_d = shift_q;
              end
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + CNT_ONE;
          end else if (byte_end) begin
            oe_d    = 1'b0;
            ptr_d   = ptr_q + PTR_W'(1);
            state_d = ST_RD_ACK;
          end else if (scl_fall) begin
            shift_d = {shift_q[BYTE_W-2:0], 1'b0};
            oe_d    = ~shift_q[BYTE_W-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              shift_d = reg_rdata;
              oe_d    = ~reg_rdata[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_RD;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b1;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      wdata_q <= wdata_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_addr  = ptr_q;

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state_q == ST_IDLE) && !oe_q);

  p_mismatch_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && byte_end && !addr_hit) |=> (state_q == ST_SKIP) && !oe_q);

  p_strobe_in_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (state_q == ST_WR_ACK) && oe_q);

  p_master_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK && scl_fall && !mack_q) |=> (state_q == ST_SKIP) && !oe_q);

  p_busy_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && byte_end && nv_busy) |=> !oe_q);

  p_restart_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state_q == ST_ADDR) && first_q);

  p_oe_low_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> (!$past(scl_f) || $past(start_ev) || $past(stop_ev)));
endmodule

// File: rtl/twi_slave_top.sv
module twi_slave_top #(
  parameter logic [6:0] DEV_ADDR    = 7'h5A,
  parameter int         PTR_W       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             nv_busy,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);
  localparam int N_LINES = 2;
  localparam int L_SCL   = 0;
  localparam int L_SDA   = 1;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] raw_l;
  logic [N_LINES-1:0] flt_l;
  logic               scl_rise, scl_fall, start_ev, stop_ev;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_l[L_SCL] = scl_i;
  assign raw_l[L_SDA] = sda_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    twi_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .line_i(raw_l[g]),
      .line_o(flt_l[g])
    );
  end

  twi_bus_events u_evt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_f   (flt_l[L_SCL]),
    .sda_f   (flt_l[L_SDA]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  twi_byte_engine #(
    .DEV_ADDR(DEV_ADDR),
    .PTR_W   (PTR_W)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_f    (flt_l[L_SCL]),
    .sda_f    (flt_l[L_SDA]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .nv_busy  (nv_busy),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> !sda_oe && !reg_we);
endmodule

// File: tb/twi_slave_top_bench.sv
module twi_slave_top_bench;
  localparam int         Q   = 16;
  localparam logic [6:0] DEV = 7'h5A;
  localparam int         PW  = 4;
  localparam int         NV  = 6;
  // {address byte, pointer, data, expected address ack}
  localparam logic [31:0] VEC [NV] = '{
    {8'hB4, 8'h02, 8'h3C, 8'h01},
    {8'hB4, 8'h09, 8'hA5, 8'h01},
    {8'hB6, 8'h02, 8'hFF, 8'h00},
    {8'hB4, 8'h0F, 8'h81, 8'h01},
    {8'h5A, 8'h09, 8'h00, 8'h00},
    {8'hB4, 8'h00, 8'h7E, 8'h01}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl_m, sda_m, nv_busy;
  logic          sda_line;
  logic          sda_oe, reg_we;
  logic [PW-1:0] reg_addr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic [7:0]    mem     [16];
  logic [7:0]    exp_mem [16];
  int            checks = 0;
  int            failures = 0;
  int            we_cnt = 0;
  int            oe_viol = 0;
  logic          oe_prev;

  always #4 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  twi_slave_top #(.DEV_ADDR(DEV), .PTR_W(PW)) u_twi_slave_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .nv_busy(nv_busy), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'hC0 + 8'(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  // R11 monitor: the pull-down enable may only move while the clock is low
  always @(posedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(Q);
      if (glitch && i == 3) begin
        scl_m = 1'b0;  wq(2);
        scl_m = 1'b1;  wq(3);
        sda_m = ~b[i]; wq(2);
        sda_m = b[i];
      end
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = (sda_line == 1'b0);
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      scl_m = 1'b0;
    end
    wq(Q);
    sda_m = mack ? 1'b0 : 1'b1; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic read_at(input logic [7:0] p, output logic [7:0] d);
    bit a;
    bus_start;
    send_byte({DEV, 1'b0}, 1'b0, a);
    send_byte(p, 1'b0, a);
    bus_start;
    send_byte({DEV, 1'b1}, 1'b0, a);
    recv_byte(1'b0, d);
    bus_stop;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit         a;
    logic [7:0] d;
    int         w0;
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'hC0 + 8'(i);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; nv_busy = 1'b0;
    wq(5);
    chk(sda_oe == 1'b0, "R1 oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    wq(10);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 after reset", {30'd0, sda_oe, reg_we}, 0);

    // table of single-register writes with read-back
    for (int v = 0; v < NV; v++) begin
      bus_start;
      send_byte(VEC[v][31:24], 1'b0, a);
      chk(a == VEC[v][0], "R3/R4 address ack", 32'(a), 32'(VEC[v][0]));
      send_byte(VEC[v][23:16], 1'b0, a);
      chk(a == VEC[v][0], "R5 pointer ack (R4 ignored)", 32'(a), 32'(VEC[v][0]));
      send_byte(VEC[v][15:8], 1'b0, a);
      chk(a == VEC[v][0], "R5 data ack (R4 ignored)", 32'(a), 32'(VEC[v][0]));
      bus_stop;
      if (VEC[v][0]) exp_mem[VEC[v][19:16]] = VEC[v][15:8];
      read_at(VEC[v][23:16], d);
      chk(d == exp_mem[VEC[v][19:16]], "R6 read-back", 32'(d), 32'(exp_mem[VEC[v][19:16]]));
    end

    // R5 burst write with auto-increment
    w0 = we_cnt;
    bus_start;
    send_byte({DEV, 1'b0}, 1'b0, a);
    send_byte(8'h04, 1'b0, a);
    send_byte(8'h11, 1'b0, a);
    send_byte(8'h22, 1'b0, a);
    send_byte(8'h33, 1'b0, a);
    bus_stop;
    exp_mem[4] = 8'h11; exp_mem[5] = 8'h22; exp_mem[6] = 8'h33;
    chk(we_cnt - w0 == 3, "R5 one strobe per data byte", 32'(we_cnt - w0), 3);

    // R6 burst read, R7 master NACK ends it
    bus_start;
    send_byte({DEV, 1'b0}, 1'b0, a);
    send_byte(8'h04, 1'b0, a);
    bus_start;
    send_byte({DEV, 1'b1}, 1'b0, a);
    chk(a == 1'b1, "R3 read address ack", 32'(a), 1);
    recv_byte(1'b1, d);
    chk(d == 8'h11, "R6 burst byte 0", 32'(d), 32'h11);
    recv_byte(1'b1, d);
    chk(d == 8'h22, "R6 burst byte 1", 32'(d), 32'h22);
    recv_byte(1'b0, d);
    chk(d == 8'h33, "R6 burst byte 2", 32'(d), 32'h33);
    begin
      int low_seen = 0;
      for (int i = 0; i < 9; i++) begin
        wq(Q); scl_m = 1'b1; wq(Q);
        if (sda_line == 1'b0) low_seen++;
        wq(Q); scl_m = 1'b0;
      end
      wq(Q);
      chk(low_seen == 0, "R7 line released after master NACK", 32'(low_seen), 0);
    end
    bus_stop;

    // R9 repeated START resets byte phase
    bus_start;
    send_byte({DEV, 1'b0}, 1'b0, a);
    send_byte(8'h05, 1'b0, a);
    bus_start;
    send_byte({DEV, 1'b0}, 1'b0, a);
    chk(a == 1'b1, "R9 address after repeated START", 32'(a), 1);
    send_byte(8'h07, 1'b0, a);
    send_byte(8'h3C, 1'b0, a);
    bus_stop;
    exp_mem[7] = 8'h3C;
    read_at(8'h07, d);
    chk(d == 8'h3C, "R9 new pointer used", 32'(d), 32'h3C);
    read_at(8'h05, d);
    chk(d == exp_mem[5], "R9 old pointer untouched", 32'(d), 32'(exp_mem[5]));

    // R2 bytes after STOP without START
    w0 = we_cnt;
    send_byte({DEV, 1'b0}, 1'b0, a);
    chk(a == 1'b0, "R2 no ack without START", 32'(a), 0);
    send_byte(8'h01, 1'b0, a);
    chk(a == 1'b0 && we_cnt == w0, "R2 nothing written", {31'd0, a} | 32'(we_cnt - w0), 0);
    bus_stop;

    // R8 busy refusal and recovery
    nv_busy = 1'b1;
    bus_start;
    send_byte({DEV, 1'b0}, 1'b0, a);
    chk(a == 1'b0, "R8 address refused while busy", 32'(a), 0);
    bus_stop;
    nv_busy = 1'b0;
    bus_start;
    send_byte({DEV, 1'b0}, 1'b0, a);
    chk(a == 1'b1, "R8 ack resumes after busy", 32'(a), 1);
    send_byte(8'h03, 1'b0, a);
    nv_busy = 1'b1;
    send_byte(8'h99, 1'b0, a);
    chk(a == 1'b0, "R8 data refused while busy", 32'(a), 0);
    bus_stop;
    nv_busy = 1'b0;
    read_at(8'h03, d);
    chk(d == exp_mem[3], "R8 refused data not written", 32'(d), 32'(exp_mem[3]));

    // R10 short glitches on both lines during a data bit
    bus_start;
    send_byte({DEV, 1'b0}, 1'b0, a);
    send_byte(8'h06, 1'b0, a);
    send_byte(8'h96, 1'b1, a);
    chk(a == 1'b1, "R10 byte with glitches acked", 32'(a), 1);
    bus_stop;
    exp_mem[6] = 8'h96;
    read_at(8'h06, d);
    chk(d == 8'h96, "R10 glitches ignored", 32'(d), 32'h96);

    chk(oe_viol == 0, "R11 oe changes only with clock low", 32'(oe_viol), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule